// File: doc/BRIEF.md
# Feedback-Gated PWM Frame Generator

This block produces a pulse-width modulated drive for a switch-mode power stage whose frame timing is set by the load rather than by a free-running clock. A prescaler divides the system clock into base periods. A frame counter steps through a programmed number of base periods, and the output is compared against a duty value that is copied from a buffer at the start of each frame. Software may therefore rewrite the duty value at any time, and the new value takes effect on the next frame.

Two digital feedback inputs come from external comparators. The first, the release input, holds off the next frame until it reads low. A zero-crossing detector on this input lets the frame be timed by the resonant current. The second, the trip input, blanks the output for the rest of the current frame when it goes high, which gives a cycle-by-cycle over-current cut. Each frame that starts after a completed frame sets a sticky completion flag. Software clears the flag with a one-cycle pulse.

Software sets the block up by loading the configuration and the duty value while the block is disabled, and then raising the enable.

Top module: `fbpwm_frame_gen`

## Requirements
- R1: While enabled, one base period lasts `cfg_word[15:0]` system clock cycles. The count in force changes only at base-period boundaries, which are spaced exactly that many cycles apart.
- R2: A frame consists of `cfg_word[31:16]` base periods, with the count running from 1 up to that length. If the release input is already low when the last count ends, the next frame begins at once, so the frame repeats every length × base cycles.
- R3: The duty value is copied from `duty_word` only when a frame starts. A write made during a frame has no effect on that frame and shows up in the next one.
- R4: During count k, `pwm_out` is high when the captured duty is greater than or equal to k, and low otherwise. A duty of 0 keeps the output low for the whole frame. A duty above the frame length keeps it high for the whole frame.
- R5: When the last count ends while the release input `fb_release` is high, the output is held low and the count does not advance. At each later base-period boundary the release input is sampled again. The new frame starts at the first boundary where it is low.
- R6: If the trip input `fb_trip` is high at any time during a running frame, `pwm_out` goes low and stays low for the rest of that frame. The blanking ends when the next frame starts.
- R7: `frame_flag` goes to 1 when a new frame starts after a completed frame. It does not go to 1 on the first frame after enable. It stays at 1 until a one-cycle `flag_clr` pulse clears it. When a frame start and `flag_clr` fall in the same cycle, the flag ends up at 1.
- R8: While `enable` is low, `pwm_out` and `frame_flag` are 0 and all counters are held at reset. When `enable` rises, a frame starts at once using the current `duty_word`.
- R9: A base-period field or frame-length field of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Run control. When low, the block is held idle and its counters are cleared |
| cfg_word | input | 32 | Bits [15:0]: base period in clocks. Bits [31:16]: frame length in base periods |
| duty_word | input | 16 | Buffered duty value, captured when a frame starts |
| fb_release | input | 1 | Release feedback. A new frame may start only when this input is low |
| fb_trip | input | 1 | Trip feedback. When high, it blanks the output for the rest of the frame |
| flag_clr | input | 1 | One-cycle pulse that clears the completion flag |
| pwm_out | output | 1 | PWM drive output |
| frame_flag | output | 1 | Sticky flag that marks a completed frame |

## Verification
The assertions assume that `cfg_word` is constant while `enable` is high, because the period and count range checks compare live counters against the configuration in force. The stimulus changes the configuration only while the block is disabled. The feedback inputs are asynchronous and pass through two-flop synchronisers. The bench therefore changes them in the middle of a base period, at least three cycles before the boundary that must see the new value, so the expected frame start is unambiguous. Every expected output level is sampled in the middle of a count or on a known boundary cycle, counted from the enable edge.

// File: rtl/fbpwm_pkg.sv
package fbpwm_pkg;

  // Frame controller sequencing
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // disabled, everything held cleared
    ST_RUN  = 2'd1,   // stepping through the counts of a frame
    ST_WAIT = 2'd2    // last count done, waiting for release input low
  } frame_state_e;

endpackage

// File: rtl/fbpwm_sync.sv
module fbpwm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_n;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_n = din;
    end else begin : g_multi
      always_comb chain_n = {chain_q[LAST-1:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_n;
  end

  assign dout = chain_q[LAST];

endmodule

// File: rtl/fbpwm_prescaler.sv
module fbpwm_prescaler #(
  parameter int BASE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [BASE_W-1:0] base_word,
  output logic              tick
);

  localparam logic [BASE_W-1:0] ONE = {{(BASE_W-1){1'b0}}, 1'b1};

  logic [BASE_W-1:0] base_eff;
  logic [BASE_W-1:0] pc_q;
  logic [BASE_W-1:0] pc_n;
  logic              pc_en;

  // zero is treated as one
  assign base_eff = (base_word == '0) ? ONE : base_word;
  assign tick     = run && (pc_q == (base_eff - ONE));
  assign pc_en    = run || (pc_q != '0);

  always_comb begin
    pc_n = pc_q;
    if (!run)      pc_n = '0;
    else if (tick) pc_n = '0;
    else           pc_n = pc_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_n;
  end

  AST_PC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pc_q < base_eff)); // R1

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (base_eff != ONE)) |=> !tick); // R1

  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc_q == '0)); // R8

endmodule

// File: rtl/fbpwm_frame_ctrl.sv
module fbpwm_frame_ctrl
  import fbpwm_pkg::*;
#(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tick,
  input  logic               rel_hi,
  input  logic               trip_hi,
  input  logic [FRAME_W-1:0] len_word,
  input  logic [FRAME_W-1:0] duty_word,
  output logic               run,
  output logic               frame_done,
  output logic               pwm
);

  localparam logic [FRAME_W-1:0] ONE   = {{(FRAME_W-1){1'b0}}, 1'b1};
  localparam logic [FRAME_W:0]   ONE_X = {{FRAME_W{1'b0}}, 1'b1};

  frame_state_e       state_q, state_n;
  logic [FRAME_W-1:0] cnt_q, cnt_n;
  logic [FRAME_W-1:0] live_q, live_n;
  logic               out_q, out_n;
  logic               blank_q, blank_n;

  logic [FRAME_W-1:0] len_eff;
  logic [FRAME_W:0]   cnt_inc;
  logic               last_count;
  logic               start_c;

  assign len_eff    = (len_word == '0) ? ONE : len_word;
  assign cnt_inc    = {1'b0, cnt_q} + ONE_X;
  assign last_count = (cnt_q >= len_eff);

  // a new frame following a completed one
  always_comb begin
    start_c = 1'b0;
    if (enable && tick && !rel_hi) begin
      if (state_q == ST_WAIT)                     start_c = 1'b1;
      else if ((state_q == ST_RUN) && last_count) start_c = 1'b1;
    end
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    live_n  = live_q;
    out_n   = out_q;
    blank_n = blank_q;

    if (!enable) begin
      state_n = ST_IDLE;
      cnt_n   = '0;
      live_n  = '0;
      out_n   = 1'b0;
      blank_n = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          // first frame starts on enable, duty taken immediately
          state_n = ST_RUN;
          cnt_n   = ONE;
          live_n  = duty_word;
          out_n   = (duty_word != '0);
          blank_n = 1'b0;
        end
        ST_RUN: begin
          if (tick) begin
            if (last_count) begin
              if (!rel_hi) begin
                cnt_n  = ONE;
                live_n = duty_word;
                out_n  = (duty_word != '0);
              end else begin
                state_n = ST_WAIT;
                out_n   = 1'b0;
              end
            end else begin
              cnt_n = cnt_inc[FRAME_W-1:0];
              out_n = ({1'b0, live_q} >= cnt_inc);
            end
          end
          if (start_c)      blank_n = 1'b0;
          else if (trip_hi) blank_n = 1'b1;
        end
        ST_WAIT: begin
          if (start_c) begin
            state_n = ST_RUN;
            cnt_n   = ONE;
            live_n  = duty_word;
            out_n   = (duty_word != '0);
            blank_n = 1'b0;
          end
        end
        default: begin
          state_n = ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      live_q  <= '0;
      out_q   <= 1'b0;
      blank_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      live_q  <= live_n;
      out_q   <= out_n;
      blank_q <= blank_n;
    end
  end

  assign run        = enable && (state_q != ST_IDLE);
  assign frame_done = start_c;
  assign pwm        = out_q && !blank_q;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> ((cnt_q >= ONE) && (cnt_q <= len_eff))); // R2

  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (state_q != ST_IDLE) && !start_c) |=> $stable(live_q)); // R3

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_RUN) && (live_q == '0)) |-> !pwm); // R4

  AST_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !pwm); // R5

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && (state_q == ST_WAIT) && !start_c) |=> $stable(cnt_q)); // R5

  AST_BLANK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && blank_q && !start_c) |=> !pwm); // R6

endmodule

// File: rtl/fbpwm_frame_gen.sv
module fbpwm_frame_gen #(
  parameter int BASE_W      = 16,
  parameter int FRAME_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       enable,
  input  logic [BASE_W+FRAME_W-1:0]  cfg_word,
  input  logic [FRAME_W-1:0]         duty_word,
  input  logic                       fb_release,
  input  logic                       fb_trip,
  input  logic                       flag_clr,
  output logic                       pwm_out,
  output logic                       frame_flag
);

  localparam int CFG_W = BASE_W + FRAME_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic rel_s, trip_s;
  logic tick, run, frame_done, pwm;
  logic flag_q, flag_n;

  fbpwm_sync #(.STAGES(SYNC_STAGES)) u_sync_rel (
    .clk (clk), .rst_n (rst_int_n), .din (fb_release), .dout (rel_s)
  );

  fbpwm_sync #(.STAGES(SYNC_STAGES)) u_sync_trip (
    .clk (clk), .rst_n (rst_int_n), .din (fb_trip), .dout (trip_s)
  );

  fbpwm_prescaler #(.BASE_W(BASE_W)) u_presc (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (run),
    .base_word (cfg_word[BASE_W-1:0]),
    .tick      (tick)
  );

  fbpwm_frame_ctrl #(.FRAME_W(FRAME_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .enable     (enable),
    .tick       (tick),
    .rel_hi     (rel_s),
    .trip_hi    (trip_s),
    .len_word   (cfg_word[CFG_W-1:BASE_W]),
    .duty_word  (duty_word),
    .run        (run),
    .frame_done (frame_done),
    .pwm        (pwm)
  );

  // completion flag: set has priority over clear
  always_comb begin
    flag_n = flag_q;
    if (!enable)         flag_n = 1'b0;
    else if (frame_done) flag_n = 1'b1;
    else if (flag_clr)   flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) flag_q <= 1'b0;
    else            flag_q <= flag_n;
  end

  assign frame_flag = flag_q;
  assign pwm_out    = pwm;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable && frame_done) |=> frame_flag); // R7

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable && frame_flag && !flag_clr) |=> frame_flag); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_int_n)
    !enable |=> (!pwm_out && !frame_flag)); // R8

endmodule

// File: tb/fbpwm_frame_gen_tb_top.sv
module fbpwm_frame_gen_tb_top;

  logic        clk;
  logic        rst_n;
  logic        enable;
  logic [31:0] cfg_word;
  logic [15:0] duty_word;
  logic        fb_release;
  logic        fb_trip;
  logic        flag_clr;
  logic        pwm_out;
  logic        frame_flag;

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  fbpwm_frame_gen dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .cfg_word   (cfg_word),
    .duty_word  (duty_word),
    .fb_release (fb_release),
    .fb_trip    (fb_trip),
    .flag_clr   (flag_clr),
    .pwm_out    (pwm_out),
    .frame_flag (frame_flag)
  );

  int cyc;
  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    chk_pwm;
    logic  pwm;
    bit    chk_flag;
    logic  flag;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   n_run;
  int   n_fail;
  bit   done;

  task automatic check(string tag, string what, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0b expected=%0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic push(int at, bit cp, logic p, bit cf, logic f, string tag);
    exp_t e;
    e.at = at; e.chk_pwm = cp; e.pwm = p; e.chk_flag = cf; e.flag = f; e.tag = tag;
    sb.push_back(e);
  endtask

  // expected level in the middle of every count of one frame
  task automatic frame_exp(int fs, int base, int len, int duty, string tag);
    for (int k = 1; k <= len; k++)
      push(fs + (k - 1) * base + base / 2, 1'b1, (duty >= k), 1'b0, 1'b0, tag);
  endtask

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // monitor: compares scoreboard items due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].at == cyc) begin
        if (sb[i].chk_pwm)  check(sb[i].tag, "pwm_out", pwm_out, sb[i].pwm);
        if (sb[i].chk_flag) check(sb[i].tag, "frame_flag", frame_flag, sb[i].flag);
        sb.delete(i);
      end else if (sb[i].at < cyc) begin
        check(sb[i].tag, "missed sample", 1'b0, 1'b1);
        sb.delete(i);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (!done && cyc > 20000) begin
      done = 1'b1;
      check("WATCHDOG", "run finished", 1'b0, 1'b1);
      report();
    end
  end

  initial begin
    int c0, p, c2, c1;
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; enable = 1'b0; cfg_word = '0; duty_word = '0;
    fb_release = 1'b0; fb_trip = 1'b0; flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "reset pwm_out", pwm_out, 1'b0);
    check("R8", "reset frame_flag", frame_flag, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // base 8 cycles, frame of 4 counts, duty 2
    cfg_word  = {16'd4, 16'd8};
    duty_word = 16'd2;
    c0 = cyc;
    p  = c0 + 89;
    enable = 1'b1;

    frame_exp(c0 + 1, 8, 4, 2, "R4");
    push(c0 + 5, 1'b0, 1'b0, 1'b1, 1'b0, "R7");    // no flag on first frame
    push(c0 + 8, 1'b1, 1'b1, 1'b0, 1'b0, "R1");    // last cycle of count 1
    push(c0 + 16, 1'b1, 1'b1, 1'b0, 1'b0, "R1");   // last cycle of count 2
    push(c0 + 17, 1'b1, 1'b0, 1'b0, 1'b0, "R1");   // first cycle of count 3
    push(c0 + 32, 1'b1, 1'b0, 1'b0, 1'b0, "R2");   // last cycle of frame 1
    frame_exp(c0 + 33, 8, 4, 3, "R3");             // frame 2 uses duty 3
    push(c0 + 33, 1'b1, 1'b1, 1'b1, 1'b1, "R2");   // next frame right on time
    push(c0 + 43, 1'b0, 1'b0, 1'b1, 1'b0, "R7");   // cleared by pulse
    push(c0 + 66, 1'b1, 1'b0, 1'b0, 1'b0, "R5");   // waiting, output low
    push(c0 + 75, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    push(c0 + 84, 1'b1, 1'b0, 1'b1, 1'b0, "R5");
    push(p, 1'b1, 1'b1, 1'b1, 1'b1, "R7");         // set wins over clear
    push(p + 4, 1'b1, 1'b1, 1'b0, 1'b0, "R5");
    push(p + 9, 1'b1, 1'b1, 1'b0, 1'b0, "R6");
    push(p + 14, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    push(p + 20, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    push(p + 28, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
    push(p + 36, 1'b1, 1'b1, 1'b0, 1'b0, "R6");    // blanking ends
    frame_exp(p + 64, 8, 4, 9, "R4");              // duty above length
    frame_exp(p + 96, 8, 4, 0, "R4");              // duty zero
    push(p + 130, 1'b1, 1'b1, 1'b0, 1'b0, "R4");
    push(p + 134, 1'b1, 1'b0, 1'b1, 1'b0, "R8");   // disabled

    wait_to(c0 + 10);
    duty_word = 16'd3;                             // R3 mid-frame write
    wait_to(c0 + 40);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    wait_to(c0 + 50);
    fb_release = 1'b1;                             // R5 hold off
    duty_word  = 16'd4;
    wait_to(c0 + 84);
    fb_release = 1'b0;
    wait_to(c0 + 88);
    flag_clr = 1'b1;                               // coincides with start
    @(negedge clk);
    flag_clr = 1'b0;
    wait_to(p + 10);
    fb_trip = 1'b1;                                // R6 trip pulse
    wait_to(p + 12);
    fb_trip = 1'b0;
    wait_to(p + 40);
    duty_word = 16'd9;
    wait_to(p + 70);
    duty_word = 16'd0;
    wait_to(p + 100);
    duty_word = 16'd4;
    wait_to(p + 132);
    enable = 1'b0;                                 // R8
    wait_to(p + 136);
    duty_word = 16'd3;

    // re-enable: immediate start with current duty
    wait_to(p + 140);
    c2 = cyc;
    push(c2 + 1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
    push(c2 + 2, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
    push(c2 + 29, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
    enable = 1'b1;
    wait_to(c2 + 40);
    enable = 1'b0;
    wait_to(c2 + 42);
    cfg_word  = 32'd0;                             // R9 zero fields
    duty_word = 16'd1;
    wait_to(c2 + 44);
    c1 = cyc;
    for (int k = 1; k <= 6; k++)
      push(c1 + k, 1'b1, 1'b1, 1'b0, 1'b0, "R9");
    push(c1 + 4, 1'b0, 1'b0, 1'b1, 1'b1, "R9");
    enable = 1'b1;
    wait_to(c1 + 10);

    while (sb.size() != 0) @(negedge clk);
    done = 1'b1;
    report();
  end

endmodule